// File: doc/BRIEF.md
# Block-Copy Synchronous Memory

This block is a 64-word by 8-bit synchronous memory with a small copy engine built in. When the engine is idle, the memory works as a plain single-port RAM. A write happens on a clock edge when write enable is high. A read returns the word at the address captured on an edge, and that word stays on the output for the following cycle.

Three parameter registers hold the copy setup: a byte count, a source address and a destination address. Each register has its own strobe and takes its value from the address bus. A start pulse launches the copy. The engine then moves the bytes one at a time, in ascending address order. Each byte uses a read cycle at the source followed by a write cycle at the destination, with the fetched byte held in the memory's output register between the two cycles. The busy flag covers the whole copy. While the copy runs, all user-side controls are locked out.

Top module: `blkcopy_sram`

## Requirements
- R1: The active-high reset acts asynchronously. During and after reset, busy is 0, rd_data is 0, and the count, source and destination registers are 0.
- R2: While idle, wr_en high at a rising edge stores wr_data at addr. The word at the address sampled on an edge appears on rd_data after that edge and holds for the next cycle.
- R3: While idle, each of load_count, load_src and load_dst copies addr into its own register at a rising edge. The other two registers are left unchanged.
- R4: While idle, a copy_go sampled high with a nonzero count starts a copy, and busy is 1 from the next cycle. Without copy_go, busy stays 0.
- R5: A copy of N bytes keeps busy high for exactly 2*N cycles. Each byte takes a read cycle at the source followed by a write cycle at the destination.
- R6: After a copy, the source and destination registers point one past the last byte moved, and the count is 0. Loading only a new count and starting again continues the copy from there.
- R7: The source and destination addresses wrap from 63 to 0 during a copy.
- R8: Bytes move in ascending order, one at a time. When the destination is 2 above the source, a copy repeats the first two source bytes along the destination range.
- R9: A copy_go with a count of 0 writes nothing, and busy stays 0.
- R10: While busy, wr_en, addr, wr_data, the three load strobes and copy_go have no effect on the memory or the registers. The copy length also stays unchanged.
- R11: Reset asserted during a copy drops busy at once, without waiting for a clock edge, and clears the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| wr_data | input | 8 | Write data for idle writes |
| wr_en | input | 1 | Write enable for idle writes |
| addr | input | 6 | Memory address, also the value source for parameter loads |
| load_count | input | 1 | Load the byte count from addr |
| load_dst | input | 1 | Load the destination address from addr |
| load_src | input | 1 | Load the source address from addr |
| copy_go | input | 1 | Start a copy |
| busy | output | 1 | High while a copy is in progress |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong count or a missing decrement changes how long busy stays high. That difference is visible as soon as the copy finishes, so each copy's busy length is measured exactly. A source or destination that steps or wraps wrongly leaves a misplaced byte, which only a later read can show. For that reason, the whole memory is read back after each copy and compared against a sequential byte-by-byte model. A lockout leak while busy would show up as a stray byte or as shifted pointers on the next copy, and both are checked.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } copy_state_t;

endpackage

// File: rtl/blkcopy_mem.sv
module blkcopy_mem #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] mem_addr,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];
    logic [DW-1:0] rdata_d;
    logic [DW-1:0] rdata_q;

    // Storage array: write on the rising edge, no reset.
    always_ff @(posedge clk) begin
        if (mem_we) begin
            store_q[mem_addr] <= mem_wdata;
        end
    end

    // The read register doubles as the copy engine's byte holder.
    always_comb begin
        rdata_d = store_q[mem_addr];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign mem_q = rdata_q;

endmodule

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
    import blkcopy_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          load_count,
    input  logic          load_dst,
    input  logic          load_src,
    input  logic          copy_go,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          rd_phase,
    output logic          wr_phase,
    output logic [AW-1:0] cnt_cur,
    output logic [AW-1:0] src_cur,
    output logic [AW-1:0] dst_cur
);
    localparam logic [AW-1:0] STEP = AW'(1);

    typedef struct packed {
        copy_state_t   st;
        logic [AW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } ctrl_t;

    ctrl_t r_d;
    ctrl_t r_q;

    always_comb begin
        r_d       = r_q;
        mem_addr  = addr;
        mem_we    = 1'b0;
        mem_wdata = wr_data;
        unique case (r_q.st)
            ST_IDLE: begin
                mem_we = wr_en;
                if (load_count) r_d.cnt = addr;
                if (load_src)   r_d.src = addr;
                if (load_dst)   r_d.dst = addr;
                if (copy_go && (r_q.cnt != '0)) begin
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_addr = r_q.src;
                r_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                mem_addr  = r_q.dst;
                mem_we    = 1'b1;
                mem_wdata = mem_q;
                r_d.src   = r_q.src + STEP;
                r_d.dst   = r_q.dst + STEP;
                r_d.cnt   = r_q.cnt - STEP;
                r_d.st    = (r_q.cnt == STEP) ? ST_IDLE : ST_READ;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
            r_q.src <= '0;
            r_q.dst <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign rd_phase = (r_q.st == ST_READ);
    assign wr_phase = (r_q.st == ST_WRITE);
    assign cnt_cur  = r_q.cnt;
    assign src_cur  = r_q.src;
    assign dst_cur  = r_q.dst;

endmodule

// File: rtl/blkcopy_sram.sv
module blkcopy_sram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          load_count,
    input  logic          load_dst,
    input  logic          load_src,
    input  logic          copy_go,
    output logic          busy,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_q;
    logic          rd_phase;
    logic          wr_phase;
    logic [AW-1:0] cnt_cur;
    logic [AW-1:0] src_cur;
    logic [AW-1:0] dst_cur;

    blkcopy_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .addr       (addr),
        .load_count (load_count),
        .load_dst   (load_dst),
        .load_src   (load_src),
        .copy_go    (copy_go),
        .mem_q      (mem_q),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .rd_phase   (rd_phase),
        .wr_phase   (wr_phase),
        .cnt_cur    (cnt_cur),
        .src_cur    (src_cur),
        .dst_cur    (dst_cur)
    );

    blkcopy_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_q     (mem_q)
    );

    assign rd_data = mem_q;

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          copy_go,
    input logic          busy,
    input logic          rd_phase,
    input logic          wr_phase,
    input logic          mem_we,
    input logic [AW-1:0] cnt_cur,
    input logic [AW-1:0] src_cur,
    input logic [AW-1:0] dst_cur
);
    localparam logic [AW-1:0] ONE = AW'(1);

    assert_go_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && copy_go && cnt_cur != '0) |=> busy);

    assert_no_spurious_start_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !copy_go) |=> !busy);

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && copy_go && cnt_cur == '0) |=> !busy);

    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (rst)
        rd_phase |=> wr_phase);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        wr_phase |=> (cnt_cur == $past(cnt_cur) - ONE));

    assert_addr_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        wr_phase |=> (src_cur == $past(src_cur) + ONE && dst_cur == $past(dst_cur) + ONE));

    assert_user_write_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_phase) |-> !mem_we);

    assert_regs_locked_R10: assert property (@(posedge clk) disable iff (rst)
        rd_phase |=> $stable(cnt_cur) && $stable(src_cur) && $stable(dst_cur));

endmodule

bind blkcopy_sram blkcopy_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .copy_go  (copy_go),
    .busy     (busy),
    .rd_phase (rd_phase),
    .wr_phase (wr_phase),
    .mem_we   (mem_we),
    .cnt_cur  (cnt_cur),
    .src_cur  (src_cur),
    .dst_cur  (dst_cur)
);

// File: tb/tb_blkcopy_sram.sv
module tb_blkcopy_sram;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic       load_count = 1'b0;
    logic       load_dst = 1'b0;
    logic       load_src = 1'b0;
    logic       copy_go = 1'b0;
    logic       busy;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [64];
    int m_cnt = 0;
    int m_src = 0;
    int m_dst = 0;

    always #10 clk = ~clk;

    blkcopy_sram dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .addr(addr),
        .load_count(load_count), .load_dst(load_dst), .load_src(load_src),
        .copy_go(copy_go), .busy(busy), .rd_data(rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_byte(int a, logic [7:0] d);
        wr_en = 1'b1; addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic read_check(int a, string tag);
        addr = 6'(a);
        @(negedge clk);
        check(tag, 32'(rd_data), 32'(exp_mem[a]));
    endtask

    task automatic verify_all(string tag);
        for (int i = 0; i < 64; i++) read_check(i, tag);
    endtask

    task automatic load_cnt(int v);
        load_count = 1'b1; addr = 6'(v); @(negedge clk); load_count = 1'b0; m_cnt = v;
    endtask
    task automatic load_s(int v);
        load_src = 1'b1; addr = 6'(v); @(negedge clk); load_src = 1'b0; m_src = v;
    endtask
    task automatic load_d(int v);
        load_dst = 1'b1; addr = 6'(v); @(negedge clk); load_dst = 1'b0; m_dst = v;
    endtask

    // Start a copy, measure busy length, update the model sequentially.
    task automatic run_copy(string tag, bit disturb);
        int cycles = 0;
        int n = m_cnt;
        copy_go = 1'b1;
        @(negedge clk);
        copy_go = 1'b0;
        while (busy && cycles < 400) begin
            if (disturb && cycles == 2) begin
                wr_en = 1'b1; addr = 6'd5; wr_data = 8'hEE;
                load_count = 1'b1; load_src = 1'b1; load_dst = 1'b1; copy_go = 1'b1;
            end
            if (disturb && cycles == 5) begin
                wr_en = 1'b0; load_count = 1'b0; load_src = 1'b0;
                load_dst = 1'b0; copy_go = 1'b0;
            end
            cycles++;
            @(negedge clk);
        end
        wr_en = 1'b0; load_count = 1'b0; load_src = 1'b0; load_dst = 1'b0; copy_go = 1'b0;
        check({tag, " busy length"}, 32'(cycles), 32'(2 * n));
        for (int i = 0; i < n; i++) exp_mem[(m_dst + i) % 64] = exp_mem[(m_src + i) % 64];
        m_src = (m_src + n) % 64;
        m_dst = (m_dst + n) % 64;
        m_cnt = 0;
    endtask

    task automatic t_reset();
        #5;
        check("R1 busy in reset", 32'(busy), 0);
        check("R1 rd_data in reset", 32'(rd_data), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 0);
        copy_go = 1'b1; @(negedge clk); copy_go = 1'b0;
        check("R1 count cleared so go does nothing", 32'(busy), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) write_byte(i, 8'((i * 37 + 11) & 255));
        verify_all("R2 idle write/read");
        addr = 6'd9; @(negedge clk);
        addr = 6'd40;
        check("R2 rd_data holds until next capture", 32'(rd_data), 32'(exp_mem[9]));
        @(negedge clk);
        check("R2 new address one cycle later", 32'(rd_data), 32'(exp_mem[40]));
    endtask

    task automatic t_basic();
        load_d(20); load_cnt(5); load_s(2);
        run_copy("R3 R4 R5 basic copy", 1'b0);
        verify_all("R4 basic copy contents");
    endtask

    task automatic t_chain();
        load_cnt(3);
        run_copy("R6 chained copy", 1'b0);
        verify_all("R6 chained contents");
    endtask

    task automatic t_wrap();
        load_cnt(6); load_s(61); load_d(30);
        run_copy("R7 source wrap", 1'b0);
        load_cnt(4); load_s(10); load_d(62);
        run_copy("R7 destination wrap", 1'b0);
        verify_all("R7 wrap contents");
    endtask

    task automatic t_overlap();
        load_cnt(6); load_s(40); load_d(42);
        run_copy("R8 forward overlap", 1'b0);
        verify_all("R8 forward overlap contents");
        check("R8 pattern repeats", 32'(exp_mem[46]), 32'(exp_mem[42]));
        load_cnt(5); load_s(52); load_d(50);
        run_copy("R8 backward overlap", 1'b0);
        verify_all("R8 backward overlap contents");
    endtask

    task automatic t_zero();
        load_cnt(0); load_s(1); load_d(33);
        run_copy("R9 zero count", 1'b0);
        check("R9 busy stays low", 32'(busy), 0);
        read_check(33, "R9 no write at destination");
    endtask

    task automatic t_locked();
        load_cnt(7); load_s(12); load_d(24);
        run_copy("R10 inputs ignored while busy", 1'b1);
        verify_all("R10 memory untouched by user port");
        copy_go = 1'b1; @(negedge clk); copy_go = 1'b0;
        check("R10 count load ignored while busy", 32'(busy), 0);
    endtask

    task automatic t_abort();
        load_cnt(10); load_s(0); load_d(32);
        copy_go = 1'b1; @(negedge clk); copy_go = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R11 busy before abort", 32'(busy), 1);
        #5 rst = 1'b1;
        #1 check("R11 busy drops at once", 32'(busy), 0);
        check("R11 rd_data cleared", 32'(rd_data), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        copy_go = 1'b1; @(negedge clk); copy_go = 1'b0;
        check("R11 count cleared by reset", 32'(busy), 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_fill();
        t_basic();
        t_chain();
        t_wrap();
        t_overlap();
        t_zero();
        t_locked();
        t_abort();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule